// File: doc/BRIEF.md
# Clock Generator Configuration Register Bank

This block is the configuration store of a multi-output system clock generator. It samples the five frequency-select straps and the 24/48 select strap once, at the clock edge that follows the release of power-on reset, and keeps them for the rest of operation. Seven 8-bit control bytes are written over a byte-addressed register port with a 3-bit address, 8-bit write data and a write strobe.

From these bytes the block derives several control outputs for the PLLs, dividers and output drivers. They are the effective 5-bit frequency code, a spread-spectrum enable, a tristate-all request, the 24/48 select, and one enable per clock output. The frequency code is taken from the latched straps unless an override bit in byte 0 hands it to register bits. Read data is combinational from the address. On readback, a fixed revision code takes the place of the frequency bits of byte 0, and the latched strap values appear in read-only positions of bytes 1 and 4. An asynchronous active-low power-down input turns off every output enable for as long as it is low, and the stored bytes are kept.

Top module: `clkcfg_regbank`

## Requirements
- R1: Straps fs_strap_i and half_sel_i are captured at the first rising clock edge after rst_n goes high. Later strap changes affect neither freq_code_o, sel_24m_o nor any readback.
- R2: Byte 0 resets to 0x00. While byte 0 bit 3 is 0, freq_code_o equals the latched straps.
- R3: While byte 0 bit 3 is 1, freq_code_o is {bit2, bit7, bit6, bit5, bit4} of byte 0, MSB first.
- R4: Byte 0 bit 1 drives spread_en_o and bit 0 drives tristate_o. Each register-driven output changes at the clock edge that takes the write.
- R5: A read of byte 0 returns bits 3,1,0 as written, REV_CODE[3:0] in bits 7:4 and REV_CODE[4] in bit 2. With the default REV_CODE of 5'b10110, a zero byte reads 0x64.
- R6: In byte 1, bit 0 enables the free-running SDRAM output, bit 2 the 48 MHz output and bit 4 the 24/48 output. Bits 7,6,5 read the latched FS3, FS0, FS2 and ignore writes. Bits 3 and 1 read 0. The byte resets to 0x15 stored.
- R7: Byte 2 holds sdram_en[7:0] and byte 3 holds pci_en[7:0], bit n for output n, both resetting to 0xFF. Byte 4 bit 7 enables 66 MHz output 2, bit 6 output 0, bit 5 output 1, bit 3 the APIC output, and bits 1:0 the CPU outputs. Byte 4 resets to those enables set. Byte 5 bits 3:0 hold sdram_en[11:8] and reset to 1, while bits 7:4 read 0.
- R8: Byte 4 bits 4 and 2 read the latched FS4 and FS1 and ignore writes.
- R9: Byte 6 always reads 0x06; writes to it change nothing.
- R10: While pwrdn_n is 0, every output enable is 0 with no clock needed. When it returns to 1, the stored enables reappear.
- R11: sel_24m_o is the latched half_sel_i: 1 selects 24 MHz and 0 selects 48 MHz.
- R12: A write to address 7 changes no byte, and address 7 reads 0x00.
- R13: rdata_o follows addr_i combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| pwrdn_n | input | 1 | Active-low asynchronous power-down |
| fs_strap_i | input | 5 | Frequency-select straps, FS4..FS0 |
| half_sel_i | input | 1 | 24/48 select strap (1 = 24 MHz) |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| freq_code_o | output | 5 | Effective frequency code |
| spread_en_o | output | 1 | Spread-spectrum enable |
| tristate_o | output | 1 | Tristate-all request |
| sel_24m_o | output | 1 | Latched 24/48 select |
| sdram_en_o | output | 12 | SDRAM clock enables |
| sdram_free_en_o | output | 1 | Free-running SDRAM clock enable |
| pci_en_o | output | 8 | PCI clock enables |
| mid66_en_o | output | 3 | 66 MHz clock enables |
| apic_en_o | output | 1 | APIC clock enable |
| cpu_en_o | output | 2 | CPU clock enables |
| usb48_en_o | output | 1 | 48 MHz clock enable |
| dual_en_o | output | 1 | 24/48 clock enable |

## Verification
A write is presented for one full cycle, from one falling edge to the next. The register-driven outputs take the new value at the rising edge in between, so the bench checks them at the following falling edge, one edge after the strobe. Read data and the power-down gating are combinational, so the bench checks them 1 ns after driving the address or pwrdn_n, with no clock in between. The straps are captured at the first rising edge after reset is released, so the reset checks are made at the falling edge after that one.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int CFG_BYTES = 7;
  localparam int BYTE_W    = 8;
  localparam int FS_W      = 5;

  typedef logic [BYTE_W-1:0] cfg_byte_t;

  localparam int IDX_MODE = 0;
  localparam int IDX_MISC = 1;
  localparam int IDX_SDLO = 2;
  localparam int IDX_PCI  = 3;
  localparam int IDX_HOST = 4;
  localparam int IDX_SDHI = 5;
  localparam int IDX_RSVD = 6;

  // Bits that a write may change, per byte
  function automatic cfg_byte_t wr_mask(input int idx);
    case (idx)
      IDX_MODE: return 8'hFF;
      IDX_MISC: return 8'h15;
      IDX_SDLO: return 8'hFF;
      IDX_PCI:  return 8'hFF;
      IDX_HOST: return 8'hEB;
      IDX_SDHI: return 8'h0F;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic cfg_byte_t rst_val(input int idx);
    case (idx)
      IDX_MODE: return 8'h00;
      IDX_MISC: return 8'h15;
      IDX_SDLO: return 8'hFF;
      IDX_PCI:  return 8'hFF;
      IDX_HOST: return 8'hEB;
      IDX_SDHI: return 8'h0F;
      IDX_RSVD: return 8'h06;
      default:  return 8'h00;
    endcase
  endfunction

  // Register-selected frequency code: bit2 is the MSB, then bits 7..4
  function automatic logic [FS_W-1:0] reg_code(input cfg_byte_t b);
    return {b[2], b[7:4]};
  endfunction

  function automatic cfg_byte_t mode_view(input cfg_byte_t b, input logic [FS_W-1:0] rev);
    return {rev[3:0], b[3], rev[4], b[1:0]};
  endfunction

  // fs is FS4..FS0
  function automatic cfg_byte_t misc_view(input cfg_byte_t b, input logic [FS_W-1:0] fs);
    return {fs[3], fs[0], fs[2], b[4:0]};
  endfunction

  function automatic cfg_byte_t host_view(input cfg_byte_t b, input logic [FS_W-1:0] fs);
    return {b[7:5], fs[4], b[3], fs[1], b[1:0]};
  endfunction
endpackage

// File: rtl/clkcfg_strap_latch.sv
module clkcfg_strap_latch #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic         captured_o,
  output logic [W-1:0] value_o
);
  logic         done_q;
  logic [W-1:0] val_q;
  logic         capture_evt;

  assign capture_evt = !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      val_q  <= '0;
    end else if (capture_evt) begin
      done_q <= 1'b1;
      val_q  <= pins_i;
    end
  end

  assign captured_o = done_q;
  assign value_o    = val_q;

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> $stable(val_q));

  // R1
  strap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_q) |-> done_q);
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
#(
  parameter int NB = CFG_BYTES,
  parameter int AW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         addr_i,
  input  cfg_byte_t             wdata_i,
  output logic [NB-1:0][BYTE_W-1:0] regs_o
);
  logic [NB-1:0] wr_hit;
  logic          wr_outside;

  assign wr_outside = wr_en_i && (int'(addr_i) >= NB);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam cfg_byte_t MASK = wr_mask(i);
    localparam cfg_byte_t RST  = rst_val(i);
    cfg_byte_t q;

    assign wr_hit[i] = wr_en_i && (addr_i == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RST;
      else if (wr_hit[i]) q <= (wdata_i & MASK) | (q & ~MASK);
    end

    assign regs_o[i] = q;
  end

  // R12
  wr_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_outside |=> $stable(regs_o));

  // R4
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(regs_o));

  // R9
  rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[IDX_RSVD] |=> $stable(regs_o[IDX_RSVD]));
endmodule

// File: rtl/clkcfg_readback.sv
module clkcfg_readback
  import clkcfg_pkg::*;
#(
  parameter int NB = CFG_BYTES,
  parameter int AW = 3,
  parameter logic [FS_W-1:0] REV = 5'b10110
) (
  input  logic [NB-1:0][BYTE_W-1:0] regs_i,
  input  logic [FS_W-1:0]           fs_i,
  input  logic [AW-1:0]             addr_i,
  output cfg_byte_t                 rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      IDX_MODE: rdata_o = mode_view(regs_i[IDX_MODE], REV);
      IDX_MISC: rdata_o = misc_view(regs_i[IDX_MISC], fs_i);
      IDX_SDLO: rdata_o = regs_i[IDX_SDLO];
      IDX_PCI:  rdata_o = regs_i[IDX_PCI];
      IDX_HOST: rdata_o = host_view(regs_i[IDX_HOST], fs_i);
      IDX_SDHI: rdata_o = regs_i[IDX_SDHI];
      IDX_RSVD: rdata_o = regs_i[IDX_RSVD];
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter logic [4:0] REV_CODE = 5'b10110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwrdn_n,
  input  logic [4:0]  fs_strap_i,
  input  logic        half_sel_i,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic [4:0]  freq_code_o,
  output logic        spread_en_o,
  output logic        tristate_o,
  output logic        sel_24m_o,
  output logic [11:0] sdram_en_o,
  output logic        sdram_free_en_o,
  output logic [7:0]  pci_en_o,
  output logic [2:0]  mid66_en_o,
  output logic        apic_en_o,
  output logic [1:0]  cpu_en_o,
  output logic        usb48_en_o,
  output logic        dual_en_o
);
  localparam int AW     = 3;
  localparam int STRAPW = FS_W + 1;

  logic [CFG_BYTES-1:0][BYTE_W-1:0] regs;
  logic                 strap_done;
  logic [STRAPW-1:0]    strap_val;
  logic [FS_W-1:0]      fs_lat;
  logic                 code_override;
  logic                 gate;

  clkcfg_strap_latch #(.W(STRAPW)) u_strap (
    .clk(clk), .rst_n(rst_n), .pins_i({half_sel_i, fs_strap_i}),
    .captured_o(strap_done), .value_o(strap_val)
  );

  clkcfg_regs #(.NB(CFG_BYTES), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .regs_o(regs)
  );

  clkcfg_readback #(.NB(CFG_BYTES), .AW(AW), .REV(REV_CODE)) u_rd (
    .regs_i(regs), .fs_i(fs_lat), .addr_i(addr_i), .rdata_o(rdata_o)
  );

  assign fs_lat        = strap_val[FS_W-1:0];
  assign sel_24m_o     = strap_val[FS_W];
  assign code_override = regs[IDX_MODE][3];
  assign freq_code_o   = code_override ? reg_code(regs[IDX_MODE]) : fs_lat;
  assign spread_en_o   = regs[IDX_MODE][1];
  assign tristate_o    = regs[IDX_MODE][0];

  assign gate = pwrdn_n;

  assign sdram_en_o      = {regs[IDX_SDHI][3:0], regs[IDX_SDLO]} & {12{gate}};
  assign pci_en_o        = regs[IDX_PCI] & {8{gate}};
  assign sdram_free_en_o = regs[IDX_MISC][0] & gate;
  assign usb48_en_o      = regs[IDX_MISC][2] & gate;
  assign dual_en_o       = regs[IDX_MISC][4] & gate;
  assign mid66_en_o      = {regs[IDX_HOST][7], regs[IDX_HOST][5], regs[IDX_HOST][6]} & {3{gate}};
  assign apic_en_o       = regs[IDX_HOST][3] & gate;
  assign cpu_en_o        = regs[IDX_HOST][1:0] & {2{gate}};

  // R2
  code_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en_i) && $past(strap_done)) |-> $stable(freq_code_o));

  // R4
  tristate_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_i) |-> ($stable(tristate_o) && $stable(spread_en_o)));

  // R10
  pwrdn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |-> (sdram_en_o == '0 && pci_en_o == '0 && mid66_en_o == '0 &&
                  cpu_en_o == '0 && !apic_en_o && !usb48_en_o && !dual_en_o &&
                  !sdram_free_en_o));
endmodule

// File: tb/clkcfg_regbank_bench.sv
module clkcfg_regbank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn_n = 1'b1;
  logic [4:0] fs = 5'b01101;
  logic hsel = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] code;
  logic spread, tri_o, sel24;
  logic [11:0] sd_en;
  logic sdf_en;
  logic [7:0] pci_en;
  logic [2:0] m66_en;
  logic apic_en;
  logic [1:0] cpu_en;
  logic usb_en, dual_en;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  clkcfg_regbank u_clkcfg_regbank (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .fs_strap_i(fs),
    .half_sel_i(hsel), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .freq_code_o(code), .spread_en_o(spread),
    .tristate_o(tri_o), .sel_24m_o(sel24), .sdram_en_o(sd_en),
    .sdram_free_en_o(sdf_en), .pci_en_o(pci_en), .mid66_en_o(m66_en),
    .apic_en_o(apic_en), .cpu_en_o(cpu_en), .usb48_en_o(usb_en),
    .dual_en_o(dual_en)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst_n = 1'b0;
    #35;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R2 code from straps", code, 5'b01101);
    check("R4 spread reset", spread, 0);
    check("R4 tristate reset", tri_o, 0);
    check("R11 select latched", sel24, 1);
    rd(0, d); check("R5 byte0 reset read", d, 8'h64);
    rd(1, d); check("R6 byte1 reset read", d, 8'hF5);
    rd(2, d); check("R7 byte2 reset read", d, 8'hFF);
    rd(3, d); check("R7 byte3 reset read", d, 8'hFF);
    rd(4, d); check("R8 byte4 reset read", d, 8'hEB);
    rd(5, d); check("R7 byte5 reset read", d, 8'h0F);
    rd(6, d); check("R9 byte6 reset read", d, 8'h06);
    rd(7, d); check("R12 addr7 read", d, 8'h00);
    check("R7 enables reset", {sd_en, pci_en, m66_en, apic_en, cpu_en}, {12'hFFF, 8'hFF, 3'h7, 1'b1, 2'h3});
    check("R6 misc enables reset", {sdf_en, usb_en, dual_en}, 3'b111);
  endtask

  task automatic t_strap_hold();
    logic [7:0] d;
    fs = 5'b10010; hsel = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 code after strap change", code, 5'b01101);
    check("R1 select after strap change", sel24, 1);
    rd(1, d); check("R1 byte1 after strap change", d, 8'hF5);
    rd(4, d); check("R1 byte4 after strap change", d, 8'hEB);
  endtask

  task automatic t_override();
    logic [7:0] d;
    wr(0, 8'h3C);
    check("R3 override code", code, 5'b10011);
    rd(0, d); check("R5 byte0 readback with override", d, 8'h6C);
    wr(0, 8'hA8);
    check("R3 override code 2", code, 5'b01010);
    wr(0, 8'hF4);
    check("R2 override off restores straps", code, 5'b01101);
  endtask

  task automatic t_spread_tri();
    logic [7:0] d;
    @(negedge clk);
    addr = 0; wdata = 8'h03; wr_en = 1'b1;
    #1 check("R4 no change before edge", {spread, tri_o}, 2'b00);
    @(negedge clk) wr_en = 1'b0;
    check("R4 spread and tristate set", {spread, tri_o}, 2'b11);
    rd(0, d); check("R5 byte0 readback", d, 8'h67);
    wr(0, 8'h02);
    check("R4 tristate cleared", {spread, tri_o}, 2'b10);
    wr(0, 8'h00);
  endtask

  task automatic t_misc();
    logic [7:0] d;
    wr(1, 8'h00);
    check("R6 misc enables cleared", {sdf_en, usb_en, dual_en}, 3'b000);
    rd(1, d); check("R6 byte1 read straps kept", d, 8'hE0);
    wr(1, 8'h04);
    check("R6 only 48 enabled", {sdf_en, usb_en, dual_en}, 3'b010);
    wr(1, 8'hFF);
    rd(1, d); check("R6 byte1 read-only bits", d, 8'hF5);
  endtask

  task automatic t_enables();
    logic [7:0] d;
    wr(2, 8'hA5);
    check("R7 sdram low enables", sd_en, 12'hFA5);
    wr(3, 8'h3C);
    check("R7 pci enables", pci_en, 8'h3C);
    wr(4, 8'h00);
    check("R8 host enables off", {m66_en, apic_en, cpu_en}, 6'b0);
    rd(4, d); check("R8 byte4 straps read", d, 8'h00);
    wr(4, 8'h40);
    check("R7 mid66 bit6 is output0", m66_en, 3'b001);
    wr(4, 8'h8A);
    check("R7 byte4 mapping", {m66_en, apic_en, cpu_en}, {3'b100, 1'b1, 2'b10});
    wr(4, 8'h3F);
    check("R7 byte4 mapping 2", {m66_en, apic_en, cpu_en}, {3'b010, 1'b1, 2'b11});
    rd(4, d); check("R8 byte4 read", d, 8'h2B);
    wr(5, 8'hF6);
    check("R7 sdram high enables", sd_en[11:8], 4'h6);
    rd(5, d); check("R7 byte5 reserved read", d, 8'h06);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    wr(6, 8'hFF);
    rd(6, d); check("R9 byte6 after write", d, 8'h06);
    wr(7, 8'h00);
    rd(7, d); check("R12 addr7 read after write", d, 8'h00);
    rd(2, d); check("R12 byte2 untouched", d, 8'hA5);
    rd(3, d); check("R12 byte3 untouched", d, 8'h3C);
    rd(5, d); check("R12 byte5 untouched", d, 8'h06);
    check("R12 code untouched", code, 5'b01101);
  endtask

  task automatic t_pwrdn();
    logic [7:0] d;
    wr(1, 8'h15);
    #3 pwrdn_n = 1'b0;
    #1;
    check("R10 enables off", {sd_en, pci_en, m66_en, apic_en, cpu_en, sdf_en, usb_en, dual_en}, '0);
    rd(3, d); check("R10 register kept", d, 8'h3C);
    pwrdn_n = 1'b1;
    #1;
    check("R10 enables restored", {sd_en, pci_en, sdf_en}, {12'h6A5, 8'h3C, 1'b1});
  endtask

  task automatic t_rdcomb();
    logic [7:0] d;
    @(negedge clk);
    addr = 3; #1 d = rdata;
    addr = 6; #1;
    check("R13 same-cycle read", {d, rdata}, {8'h3C, 8'h06});
  endtask

  initial begin
    t_reset();
    t_strap_hold();
    t_override();
    t_spread_tri();
    t_misc();
    t_enables();
    t_protect();
    t_pwrdn();
    t_rdcomb();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule